// File: doc/BRIEF.md
# Uncached Indexed Load/Store Unit

This unit carries out indexed loads and stores that bypass every cache and reach a memory bus directly. Each operation supplies a load/store flag, an access size of 1, 2, 4 or 8 bytes, a base-register field with that register's value, an index value and, for stores, a 64-bit source operand. The unit adds base and index to form the effective address and issues exactly one bus transaction with byte enables for the touched lanes. For a load it returns the fetched bytes zero-extended to 64 bits. When the base-register field is 0, the base operand is a literal zero rather than the register's contents.

Memory data is big-endian: the byte at the effective address is the most significant byte of the accessed field. Bus lane k carries the byte whose address has low three bits equal to k. An access whose bytes would span two 8-byte words is refused with an error pulse and no bus request. The unit takes one operation at a time. It is busy from acceptance until the bus response, then pulses a completion flag. For loads the result comes with that flag. No status state is kept.

Top module: `ucx_ldst_unit`

## Requirements
- R1: `req_addr` equals `op_base_val + op_index_val` (modulo 2^64) when the base field is nonzero.
- R2: When `op_base_sel` is 0, the base operand is 0 and `req_addr` equals `op_index_val`, whatever `op_base_val` holds.
- R3: With `op_size` coding 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes, n=2^op_size and o=`req_addr[2:0]`, `req_be` has bits o through o+n-1 set and all other bits clear.
- R4: On a store, lane o+i of `req_wdata` (bits 8(o+i)+7..8(o+i)) holds source byte n-1-i, counting source bytes from bit 0. Lanes outside the enabled range are zero, and `req_write` is 1. A load drives `req_write` 0.
- R5: On a load, result byte n-1-i (counting from bit 0) is `rsp_rdata` lane o+i for i below n. All result bits from 8n upward are zero.
- R6: If o+n exceeds 8, `align_err` is high for exactly the one cycle after acceptance. No request is issued and `busy` stays low.
- R7: An operation is accepted when `op_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the cycle of `rsp_valid`. `done` is high for exactly the one following cycle, with `busy` low.
- R8: `req_valid` rises the cycle after acceptance and stays high with address, enables, data and write flag stable until the cycle where `req_ready` is high. It drops the next cycle, and that operation issues no further request.
- R9: `result_valid` and the new `result` appear together with `done` for loads only. After a store, `result` keeps its previous value and `result_valid` stays low.
- R10: `op_valid` while `busy` is high is ignored. It causes no extra bus request and leaves the current operation's outcome unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code (0..3 = 1,2,4,8 bytes) |
| op_base_sel | input | SEL_W | Base-register field; 0 selects literal zero |
| op_base_val | input | ADDR_W | Contents of the base register |
| op_index_val | input | ADDR_W | Contents of the index register |
| op_src_val | input | 64 | Store source operand |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| result_valid | output | 1 | Load result write-back valid |
| result | output | 64 | Zero-extended load result |
| align_err | output | 1 | Word-spanning access refused |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_addr | output | ADDR_W | Effective address |
| req_write | output | 1 | Bus write flag |
| req_be | output | 8 | Byte-lane enables |
| req_wdata | output | 64 | Lane-steered store data |
| rsp_valid | input | 1 | Bus response valid |
| rsp_rdata | input | 64 | Bus read data |

## Verification
Completion of one operation and acceptance of the next can land in the same cycle. The cycle where `done` is high is also the first cycle with `busy` low, so a new `op_valid` offered there is taken. The bench does this on most consecutive operations by driving the next operation as soon as it sees `done`. It then checks that the earlier result is still correct in that cycle and that the new operation's request follows one cycle later. A second overlap comes from offering `op_valid` while a response is awaited. The bench judges this with a count of bus handshakes, which must rise by exactly one per operation.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
  localparam int LANES = 8;
  localparam int DW    = 64;
  localparam int OFS_W = 3;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } ucx_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ucx_state_e;

  // number of bytes touched by an access of the given size code
  function automatic int size_bytes(ucx_size_e s);
    return 1 << int'(s);
  endfunction

  // an access spans two bus words when its last byte falls past lane 7
  function automatic logic span_crosses(logic [OFS_W-1:0] ofs, ucx_size_e s);
    return (int'(ofs) + size_bytes(s)) > LANES;
  endfunction

  // lane is part of the access window starting at ofs
  function automatic logic lane_on(int lane, logic [OFS_W-1:0] ofs, ucx_size_e s);
    return (lane >= int'(ofs)) && (lane < int'(ofs) + size_bytes(s));
  endfunction

  // big-endian steering: first lane of the window carries the top source byte
  function automatic logic [7:0] store_byte(int lane, logic [DW-1:0] src,
                                            logic [OFS_W-1:0] ofs, ucx_size_e s);
    int pos;
    int sel;
    pos = lane - int'(ofs);
    sel = size_bytes(s) - 1 - pos;
    if (lane_on(lane, ofs, s) && sel >= 0 && sel < LANES)
      return src[8*sel +: 8];
    return 8'h00;
  endfunction

  // result byte k (k=0 is least significant) gathered from its bus lane
  function automatic logic [7:0] load_byte(int k, logic [DW-1:0] rdata,
                                           logic [OFS_W-1:0] ofs, ucx_size_e s);
    int lane;
    lane = int'(ofs) + size_bytes(s) - 1 - k;
    if (k < size_bytes(s) && lane >= 0 && lane < LANES)
      return rdata[8*lane +: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/ucx_agen.sv
module ucx_agen
  import ucx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 5
) (
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  ucx_size_e         size,
  input  logic [DW-1:0]     src_val,
  output logic [ADDR_W-1:0] ea,
  output logic [LANES-1:0]  lane_be,
  output logic [DW-1:0]     lane_wdata,
  output logic              crosses
);
  logic [ADDR_W-1:0] base_op;
  logic [OFS_W-1:0]  ofs;

  // a zero base field means the constant zero, not register zero
  assign base_op = (base_sel == '0) ? '0 : base_val;
  assign ea      = base_op + index_val;
  assign ofs     = ea[OFS_W-1:0];
  assign crosses = span_crosses(ofs, size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_be[k]          = lane_on(k, ofs, size);
    assign lane_wdata[8*k +: 8] = store_byte(k, src_val, ofs, size);
  end
endmodule

// File: rtl/ucx_load_merge.sv
module ucx_load_merge
  import ucx_pkg::*;
(
  input  logic [DW-1:0]    rdata,
  input  logic [OFS_W-1:0] ofs,
  input  ucx_size_e        size,
  output logic [DW-1:0]    merged
);
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign merged[8*k +: 8] = load_byte(k, rdata, ofs, size);
  end
endmodule

// File: rtl/ucx_bus_seq.sv
module ucx_bus_seq
  import ucx_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  ucx_size_e         op_size,
  input  logic [ADDR_W-1:0] ea,
  input  logic [LANES-1:0]  lane_be,
  input  logic [DW-1:0]     lane_wdata,
  input  logic              crosses,
  input  logic [DW-1:0]     merged,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              accept_evt,
  output logic              busy,
  output logic              done,
  output logic              result_valid,
  output logic [DW-1:0]     result,
  output logic              align_err,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic [LANES-1:0]  req_be,
  output logic [DW-1:0]     req_wdata,
  output logic [OFS_W-1:0]  lat_ofs,
  output ucx_size_e         lat_size
);
  ucx_state_e state_q;
  logic       issue_evt;
  logic       resp_evt;

  assign busy       = (state_q != ST_IDLE);
  assign accept_evt = op_valid && !busy;
  assign req_valid  = (state_q == ST_REQ);
  assign issue_evt  = req_valid && req_ready;
  assign resp_evt   = (state_q == ST_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      done         <= 1'b0;
      result_valid <= 1'b0;
      result       <= '0;
      align_err    <= 1'b0;
      req_addr     <= '0;
      req_write    <= 1'b0;
      req_be       <= '0;
      req_wdata    <= '0;
      lat_ofs      <= '0;
      lat_size     <= SZ_1B;
    end else begin
      done         <= 1'b0;
      result_valid <= 1'b0;
      align_err    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            if (crosses) begin
              align_err <= 1'b1;
            end else begin
              req_addr  <= ea;
              req_write <= op_store;
              req_be    <= lane_be;
              req_wdata <= op_store ? lane_wdata : '0;
              lat_ofs   <= ea[OFS_W-1:0];
              lat_size  <= op_size;
              state_q   <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (issue_evt) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_evt) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            if (!req_write) begin
              result       <= merged;
              result_valid <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ucx_ldst_unit.sv
module ucx_ldst_unit
  import ucx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic [SEL_W-1:0]  op_base_sel,
  input  logic [ADDR_W-1:0] op_base_val,
  input  logic [ADDR_W-1:0] op_index_val,
  input  logic [63:0]       op_src_val,
  output logic              busy,
  output logic              done,
  output logic              result_valid,
  output logic [63:0]       result,
  output logic              align_err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic [7:0]        req_be,
  output logic [63:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_rdata
);
  ucx_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  lane_be;
  logic [DW-1:0]     lane_wdata;
  logic              cross_evt;
  logic              accept_evt;
  logic [DW-1:0]     merged;
  logic [OFS_W-1:0]  lat_ofs;
  ucx_size_e         lat_size;

  assign size_in = ucx_size_e'(op_size);

  ucx_agen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_agen (
    .base_sel   (op_base_sel),
    .base_val   (op_base_val),
    .index_val  (op_index_val),
    .size       (size_in),
    .src_val    (op_src_val),
    .ea         (ea),
    .lane_be    (lane_be),
    .lane_wdata (lane_wdata),
    .crosses    (cross_evt)
  );

  ucx_load_merge u_merge (
    .rdata  (rsp_rdata),
    .ofs    (lat_ofs),
    .size   (lat_size),
    .merged (merged)
  );

  ucx_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_store     (op_store),
    .op_size      (size_in),
    .ea           (ea),
    .lane_be      (lane_be),
    .lane_wdata   (lane_wdata),
    .crosses      (cross_evt),
    .merged       (merged),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .accept_evt   (accept_evt),
    .busy         (busy),
    .done         (done),
    .result_valid (result_valid),
    .result       (result),
    .align_err    (align_err),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_be       (req_be),
    .req_wdata    (req_wdata),
    .lat_ofs      (lat_ofs),
    .lat_size     (lat_size)
  );
endmodule

// File: rtl/ucx_ldst_chk.sv
module ucx_ldst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        result_valid,
  input logic        align_err,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_ofs,
  input logic        req_write,
  input logic [7:0]  req_be,
  input logic [63:0] req_wdata,
  input logic        rsp_valid,
  input logic        accept_evt,
  input logic        cross_evt
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_be) && $stable(req_wdata)
                                && $stable(req_write) && $stable(req_ofs));
  // R8
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(rsp_valid) && $past(busy));
  // R7
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !busy);
  // R6
  err_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !busy && !req_valid);
  // R6
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(accept_evt) && $past(cross_evt));
  // R3
  be_first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_be[req_ofs]);
  // R9
  rv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> done);
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
endmodule

bind ucx_ldst_unit ucx_ldst_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .result_valid (result_valid),
  .align_err    (align_err),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_ofs      (req_addr[2:0]),
  .req_write    (req_write),
  .req_be       (req_be),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .accept_evt   (accept_evt),
  .cross_evt    (cross_evt)
);

// File: tb/test_ucx_ldst_unit.sv
`timescale 1ns/1ps
module test_ucx_ldst_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_store = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic [4:0]  op_base_sel = 5'd0;
  logic [63:0] op_base_val = '0;
  logic [63:0] op_index_val = '0;
  logic [63:0] op_src_val = '0;
  logic        busy, done, result_valid, align_err;
  logic [63:0] result;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic        req_write;
  logic [7:0]  req_be;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_rdata = '0;

  int checks = 0;
  int fails = 0;
  int nreq = 0;

  always #2.5 clk = ~clk;

  ucx_ldst_unit i_ucx_ldst_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
    .op_size(op_size), .op_base_sel(op_base_sel), .op_base_val(op_base_val),
    .op_index_val(op_index_val), .op_src_val(op_src_val), .busy(busy),
    .done(done), .result_valid(result_valid), .result(result),
    .align_err(align_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) if (rst_n && req_valid && req_ready) nreq++;

  function automatic int nbytes(int sz);
    return 1 << sz;
  endfunction

  function automatic bit exp_cross(int ofs, int sz);
    return ofs + nbytes(sz) > 8;
  endfunction

  function automatic logic [7:0] exp_be(int ofs, int sz);
    logic [15:0] m;
    m = ((16'd1 << nbytes(sz)) - 16'd1) << ofs;
    return m[7:0];
  endfunction

  function automatic logic [63:0] exp_wdata(logic [63:0] src, int ofs, int sz);
    logic [63:0] rev = '0;
    for (int i = 0; i < nbytes(sz); i++)
      rev = (rev << 8) | ((src >> (8*i)) & 64'hff);
    return rev << (8*ofs);
  endfunction

  function automatic logic [63:0] exp_load(logic [63:0] rd, int ofs, int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < nbytes(sz); i++)
      r = (r << 8) | ((rd >> (8*(ofs+i))) & 64'hff);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic do_op(bit st, int sz, logic [4:0] sel, logic [63:0] bv,
                       logic [63:0] iv, logic [63:0] sv, int rdly, int sdly);
    logic [63:0] ea, prev_res, rd;
    int ofs, n0;
    bit cr;
    ea = ((sel == 5'd0) ? 64'd0 : bv) + iv;
    ofs = int'(ea[2:0]);
    cr = exp_cross(ofs, sz);
    prev_res = result;
    n0 = nreq;
    op_valid = 1'b1; op_store = st; op_size = 2'(sz); op_base_sel = sel;
    op_base_val = bv; op_index_val = iv; op_src_val = sv;
    @(negedge clk);
    op_valid = 1'b0;
    if (cr) begin
      check(align_err == 1'b1, "R6 align_err pulse", 64'(align_err), 64'd1);
      check(!busy && !req_valid, "R6 no request/busy", {busy, req_valid}, 64'd0);
      @(negedge clk);
      check(align_err == 1'b0, "R6 single-cycle err", 64'(align_err), 64'd0);
      check(nreq == n0, "R6 request count", 64'(nreq), 64'(n0));
      return;
    end
    check(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
    for (int d = 0; d < rdly; d++) begin
      check(req_valid == 1'b1, "R8 req held", 64'(req_valid), 64'd1);
      @(negedge clk);
    end
    check(req_valid == 1'b1, "R8 req valid", 64'(req_valid), 64'd1);
    if (sel == 5'd0)
      check(req_addr == ea, "R2 zero base address", req_addr, ea);
    else
      check(req_addr == ea, "R1 effective address", req_addr, ea);
    check(req_be == exp_be(ofs, sz), "R3 byte enables", 64'(req_be), 64'(exp_be(ofs, sz)));
    check(req_write == st, "R4 write flag", 64'(req_write), 64'(st));
    if (st)
      check(req_wdata == exp_wdata(sv, ofs, sz), "R4 store lanes", req_wdata,
            exp_wdata(sv, ofs, sz));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(req_valid == 1'b0, "R8 req drops after handshake", 64'(req_valid), 64'd0);
    check(nreq == n0 + 1, "R8 one request", 64'(nreq), 64'(n0 + 1));
    // R10: offer another operation while waiting for the response
    op_valid = 1'b1; op_store = ~st; op_base_sel = 5'd3;
    op_index_val = 64'($urandom); op_src_val = {$urandom, $urandom};
    @(negedge clk);
    op_valid = 1'b0;
    for (int d = 0; d < sdly; d++) @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R10 still waiting", {done, busy}, 64'd1);
    rd = {$urandom, $urandom};
    rsp_valid = 1'b1; rsp_rdata = rd;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R7 done pulse", {done, busy}, 64'd2);
    check(result_valid == !st, "R9 result_valid", 64'(result_valid), 64'(!st));
    if (st)
      check(result == prev_res, "R9 result kept on store", result, prev_res);
    else
      check(result == exp_load(rd, ofs, sz), "R5 load result", result,
            exp_load(rd, ofs, sz));
    check(nreq == n0 + 1, "R10 no extra request", 64'(nreq), 64'(n0 + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !req_valid && !align_err && !result_valid,
          "R7 reset idle", {busy, done, req_valid, align_err, result_valid}, 64'd0);
    check(result == 64'd0, "R9 reset result", result, 64'd0);
    // directed corners
    do_op(1'b0, 0, 5'd4, 64'h1000, 64'h7, 64'd0, 0, 0);
    do_op(1'b0, 1, 5'd4, 64'h1000, 64'h6, 64'd0, 2, 1);
    do_op(1'b0, 2, 5'd4, 64'h1000, 64'h4, 64'd0, 1, 3);
    do_op(1'b0, 3, 5'd4, 64'h1000, 64'h8, 64'd0, 0, 2);
    do_op(1'b1, 0, 5'd9, 64'h2001, 64'h2, 64'h1122334455667788, 1, 0);
    do_op(1'b1, 1, 5'd9, 64'h2000, 64'h2, 64'h1122334455667788, 0, 1);
    do_op(1'b1, 2, 5'd9, 64'h2000, 64'h4, 64'h1122334455667788, 3, 0);
    do_op(1'b1, 3, 5'd9, 64'h2000, 64'h0, 64'h1122334455667788, 0, 0);
    do_op(1'b0, 2, 5'd0, 64'hdead_beef_0000_0003, 64'h3000, 64'd0, 1, 1);
    do_op(1'b1, 1, 5'd0, 64'hffff_ffff_ffff_fff1, 64'h3002, 64'hab_cd, 0, 0);
    do_op(1'b0, 1, 5'd2, 64'h0, 64'h7, 64'd0, 0, 0);
    do_op(1'b1, 3, 5'd2, 64'h1, 64'h0, 64'h55, 0, 0);
    do_op(1'b0, 2, 5'd2, 64'h5, 64'h0, 64'd0, 0, 0);
    do_op(1'b0, 0, 5'd1, 64'hffff_ffff_ffff_ffff, 64'h2, 64'd0, 0, 0);
    // constrained random mix
    for (int t = 0; t < 300; t++) begin
      logic [4:0] sel;
      sel = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      do_op(1'($urandom), int'($urandom % 4), sel, {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom},
            int'($urandom % 4), int'($urandom % 4));
      if ($urandom % 3 == 0) @(negedge clk);
    end
    report();
    $finish;
  end
endmodule